// File: doc/BRIEF.md
# Descriptor-Ring Transmit Queue Engine

This block feeds one transmit endpoint from a chain of 16-byte descriptors that software builds in memory. Each descriptor holds four 32-bit words: a flags word, the address of the following descriptor, the address of the data buffer, and a length word. When software hands a descriptor to the engine by setting its ownership flag, the engine fetches it and sends the referenced bytes out on a valid/ready byte stream. It then writes the flags word back with ownership cleared, optionally raises a done interrupt, and follows the link word to the next descriptor.

A descriptor that software still owns makes the engine park on it. Software later sets ownership and issues a resume command, and the engine fetches that same descriptor again. A zero byte count cannot be sent. Such a descriptor raises a length-error interrupt and parks the engine, so software can mark it for bypass and resume. The address of the descriptor in progress is always visible, so software can retire every descriptor before it.

Memory is reached through a single-word port. A read issued in one cycle returns its data in the next cycle, and a write is taken in the cycle it is issued.

Top module: `txq_engine`

## Requirements
- R1: After reset the engine is inactive: `q_active`=0, `cur_desc_addr`=0, no memory access, `out_valid`=0, both pending bits and both interrupts 0; while inactive it makes no memory access and offers no byte.
- R2: A start command while inactive loads `cur_desc_addr` from `cfg_start_addr`, sets `q_active`, and reads the four descriptor words at offsets 0, 4, 8, 12. With an owned, non-bypassed, non-empty descriptor, the first byte is offered 11 cycles after the edge that samples the command.
- R3: When bit 0 (ownership) of word 0 is clear, the engine parks. It sends no byte, writes nothing back, keeps `cur_desc_addr` and keeps `q_active`=1. A resume command re-reads the same descriptor.
- R4: Word 3 bits [15:0] give the byte count. Bytes are read from ascending addresses starting at the word 2 address, little-endian within each 32-bit word (address bits [1:0] select the lane). `out_last` is 1 on the final byte only.
- R5: While `out_valid`=1 and `out_ready`=0, `out_data`, `out_last` and `out_zlp` hold steady. Every byte is delivered exactly once.
- R6: One cycle after the final handshake of a descriptor, word 0 is written back with bit 0 cleared and every other bit kept. From the same edge, `cur_desc_addr` equals word 1.
- R7: If bit 6 of word 0 is set (or, with `LEGACY_ZLP`=1, bit 29 of word 3), one extra beat with `out_zlp`=1 and `out_last`=1 follows the data.
- R8: If bit 2 of word 0 is set on an owned descriptor, no byte is sent. The descriptor is written back (bit 0 cleared) and the engine advances to word 1.
- R9: An owned, non-bypassed descriptor with a byte count of 0 sets pending bit 1 (length error), sends no byte, is not written back, and parks with `cur_desc_addr` unchanged until resumed.
- R10: Pending bit 0 (done) is set at the write-back of a descriptor whose word 0 bit 7 is set, and only then.
- R11: Pending bits clear by writing 1 to the matching `irq_clr` bit, each bit independently. `irq_done` = pending bit 0 AND `irq_en[0]`; `irq_lenerr` = pending bit 1 AND `irq_en[1]`.
- R12: A stop command drops `q_active` at the next edge, except while a beat is offered. An offered beat stays valid until accepted, and `q_active` drops at that handshake edge. No further byte follows and the interrupted descriptor is not written back.
- R13: A start command while active and a resume command while inactive have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_start_addr | input | AW | Address of the first descriptor |
| cmd_start | input | 1 | Start pulse |
| cmd_stop | input | 1 | Stop pulse |
| cmd_resume | input | 1 | Resume pulse |
| q_active | output | 1 | Queue running |
| cur_desc_addr | output | AW | Address of the descriptor in progress |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| out_valid | output | 1 | Beat offered |
| out_ready | input | 1 | Sink accepts beat |
| out_data | output | 8 | Data byte |
| out_last | output | 1 | Final beat of a packet |
| out_zlp | output | 1 | Beat is a zero-length packet |
| irq_en | input | 2 | Interrupt enables (bit 0 done, bit 1 length error) |
| irq_clr | input | 2 | Write-one-to-clear of pending bits |
| irq_pend | output | 2 | Pending bits (bit 0 done, bit 1 length error) |
| irq_done | output | 1 | Done interrupt |
| irq_lenerr | output | 1 | Length-error interrupt |

## Verification
Descriptor fetch is word by word, two cycles per word. The first byte therefore appears 11 edges after the start edge, and the length error is pending 9 edges after it. The write-back of word 0 and the done pending bit appear together, one edge after the final handshake. The bench counts exactly that many edges and samples on the falling edge between them, confirming that ownership is still set before that edge and cleared after it. Outcomes that depend on the stall pattern are read only after a window long enough for the chain to park on its software-owned terminator.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam int DESC_W    = 32;
    localparam int F_OWN     = 0;
    localparam int F_SKIP    = 2;
    localparam int F_ZLP     = 6;
    localparam int F_IOC     = 7;
    localparam int F_ZLP_OLD = 29;

    typedef enum logic [3:0] {
        ST_IDLE, ST_FETCH, ST_FWAIT, ST_CHECK, ST_RDATA,
        ST_DWAIT, ST_SEND, ST_ZLP, ST_WB, ST_PARK
    } st_e;
endpackage

// File: rtl/txq_desc_fields.sv
module txq_desc_fields import txq_pkg::*; #(
    parameter int LEN_W      = 16,
    parameter bit LEGACY_ZLP = 1'b0
) (
    input  logic [DESC_W-1:0] w0_i,
    input  logic [DESC_W-1:0] w3_i,
    output logic              own_o,
    output logic              skip_o,
    output logic              ioc_o,
    output logic              zlp_o,
    output logic [LEN_W-1:0]  len_o
);
    logic unused_bits;
    assign unused_bits = ^{w0_i, w3_i};

    assign own_o  = w0_i[F_OWN];
    assign skip_o = w0_i[F_SKIP];
    assign ioc_o  = w0_i[F_IOC];
    assign len_o  = w3_i[LEN_W-1:0];

    generate
        if (LEGACY_ZLP) begin : g_zlp_old
            assign zlp_o = w3_i[F_ZLP_OLD];
        end else begin : g_zlp_new
            assign zlp_o = w0_i[F_ZLP];
        end
    endgenerate
endmodule

// File: rtl/txq_lane_pick.sv
module txq_lane_pick #(
    parameter int W = 32,
    localparam int LANES = W / 8,
    localparam int SW = $clog2(LANES)
) (
    input  logic [W-1:0]  word_i,
    input  logic [SW-1:0] sel_i,
    output logic [7:0]    byte_o
);
    logic [7:0] lanes [LANES];

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign lanes[i] = word_i[8*i +: 8];
        end
    endgenerate

    assign byte_o = lanes[sel_i];
endmodule

// File: rtl/txq_irq_bank.sv
module txq_irq_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] irq_o
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            logic pend_d, pend_q;

            always_comb begin
                pend_d = pend_q;
                if (clr_i[i]) pend_d = 1'b0;
                if (set_i[i]) pend_d = 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pend_q <= 1'b0;
                else        pend_q <= pend_d;
            end

            assign pend_o[i] = pend_q;
            assign irq_o[i]  = pend_q & en_i[i];
        end
    endgenerate
endmodule

// File: rtl/txq_engine.sv
module txq_engine import txq_pkg::*; #(
    parameter int AW         = 32,
    parameter int LEN_W      = 16,
    parameter bit LEGACY_ZLP = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     cfg_start_addr,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_resume,
    output logic              q_active,
    output logic [AW-1:0]     cur_desc_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [AW-1:0]     mem_addr,
    output logic [DESC_W-1:0] mem_wdata,
    input  logic [DESC_W-1:0] mem_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic              out_zlp,
    input  logic [1:0]        irq_en,
    input  logic [1:0]        irq_clr,
    output logic [1:0]        irq_pend,
    output logic              irq_done,
    output logic              irq_lenerr
);
    localparam int LANES = DESC_W / 8;
    localparam int LSB   = $clog2(LANES);

    typedef struct packed {
        st_e               st;
        logic [AW-1:0]     cur;
        logic [1:0]        widx;
        logic [DESC_W-1:0] w0;
        logic [DESC_W-1:0] w1;
        logic [DESC_W-1:0] w2;
        logic [DESC_W-1:0] w3;
        logic [AW-1:0]     baddr;
        logic [LEN_W-1:0]  rem;
        logic [DESC_W-1:0] word;
        logic              stop;
    } regs_t;

    regs_t q, d;

    logic             f_own, f_skip, f_ioc, f_zlp;
    logic [LEN_W-1:0] f_len;
    logic [7:0]       lane_byte;
    logic             set_done, set_len;
    logic [1:0]       irq_vec;

    txq_desc_fields #(.LEN_W(LEN_W), .LEGACY_ZLP(LEGACY_ZLP)) u_fields (
        .w0_i(q.w0), .w3_i(q.w3),
        .own_o(f_own), .skip_o(f_skip), .ioc_o(f_ioc), .zlp_o(f_zlp), .len_o(f_len)
    );

    txq_lane_pick #(.W(DESC_W)) u_pick (
        .word_i(q.word), .sel_i(q.baddr[LSB-1:0]), .byte_o(lane_byte)
    );

    txq_irq_bank #(.N(2)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .set_i({set_len, set_done}), .clr_i(irq_clr), .en_i(irq_en),
        .pend_o(irq_pend), .irq_o(irq_vec)
    );

    assign irq_done      = irq_vec[0];
    assign irq_lenerr    = irq_vec[1];
    assign q_active      = (q.st != ST_IDLE);
    assign cur_desc_addr = q.cur;

    always_comb begin
        d         = q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_last  = 1'b0;
        out_zlp   = 1'b0;
        set_done  = 1'b0;
        set_len   = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                d.stop = 1'b0;
                if (cmd_start) begin
                    d.cur  = cfg_start_addr;
                    d.widx = 2'd0;
                    d.st   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_rd   = 1'b1;
                mem_addr = q.cur + AW'({q.widx, 2'b00});
                d.st     = cmd_stop ? ST_IDLE : ST_FWAIT;
            end
            ST_FWAIT: begin
                unique case (q.widx)
                    2'd0: d.w0 = mem_rdata;
                    2'd1: d.w1 = mem_rdata;
                    2'd2: d.w2 = mem_rdata;
                    default: d.w3 = mem_rdata;
                endcase
                d.widx = q.widx + 2'd1;
                d.st   = (q.widx == 2'd3) ? ST_CHECK : ST_FETCH;
                if (cmd_stop) d.st = ST_IDLE;
            end
            ST_CHECK: begin
                if (cmd_stop) begin
                    d.st = ST_IDLE;
                end else if (!f_own) begin
                    d.st = ST_PARK;
                end else if (f_skip) begin
                    d.st = ST_WB;
                end else if (f_len == '0) begin
                    set_len = 1'b1;
                    d.st    = ST_PARK;
                end else begin
                    d.baddr = q.w2[AW-1:0];
                    d.rem   = f_len;
                    d.st    = ST_RDATA;
                end
            end
            ST_RDATA: begin
                mem_rd   = 1'b1;
                mem_addr = {q.baddr[AW-1:LSB], {LSB{1'b0}}};
                d.st     = cmd_stop ? ST_IDLE : ST_DWAIT;
            end
            ST_DWAIT: begin
                d.word = mem_rdata;
                d.st   = cmd_stop ? ST_IDLE : ST_SEND;
            end
            ST_SEND: begin
                out_valid = 1'b1;
                out_data  = lane_byte;
                out_last  = (q.rem == LEN_W'(1));
                if (cmd_stop) d.stop = 1'b1;
                if (out_ready) begin
                    d.baddr = q.baddr + AW'(1);
                    d.rem   = q.rem - LEN_W'(1);
                    if (q.stop || cmd_stop)          d.st = ST_IDLE;
                    else if (q.rem == LEN_W'(1))     d.st = f_zlp ? ST_ZLP : ST_WB;
                    else if (&q.baddr[LSB-1:0])      d.st = ST_RDATA;
                end
            end
            ST_ZLP: begin
                out_valid = 1'b1;
                out_last  = 1'b1;
                out_zlp   = 1'b1;
                if (cmd_stop) d.stop = 1'b1;
                if (out_ready) d.st = (q.stop || cmd_stop) ? ST_IDLE : ST_WB;
            end
            ST_WB: begin
                mem_wr    = 1'b1;
                mem_addr  = q.cur;
                mem_wdata = q.w0 & ~(DESC_W'(1) << F_OWN);
                set_done  = f_ioc;
                d.cur     = q.w1[AW-1:0];
                d.widx    = 2'd0;
                d.st      = cmd_stop ? ST_IDLE : ST_FETCH;
            end
            ST_PARK: begin
                if (cmd_stop) begin
                    d.st = ST_IDLE;
                end else if (cmd_resume) begin
                    d.widx = 2'd0;
                    d.st   = ST_FETCH;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/txq_engine_chk.sv
module txq_engine_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] cfg_start_addr,
    input logic          cmd_start,
    input logic          cmd_stop,
    input logic          cmd_resume,
    input logic          q_active,
    input logic [AW-1:0] cur_desc_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          out_valid,
    input logic          out_ready,
    input logic [7:0]    out_data,
    input logic          out_last,
    input logic          out_zlp,
    input logic [1:0]    irq_pend
);
    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !q_active |-> (!mem_rd && !mem_wr && !out_valid));

    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_active && cmd_start) |=> (q_active && cur_desc_addr == $past(cfg_start_addr)));

    a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_data) && $stable(out_last) && $stable(out_zlp)));

    a_r6_wb_drops_own: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (!mem_wdata[0] && mem_addr == cur_desc_addr));

    a_r10_done_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pend[0]) |-> $past(mem_wr));

    a_r12_stop_quick: assert property (@(posedge clk) disable iff (!rst_n)
        (q_active && cmd_stop && !out_valid) |=> !q_active);

    a_r13_resume_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_active && cmd_resume && !cmd_start) |=> !q_active);
endmodule

bind txq_engine txq_engine_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_start_addr(cfg_start_addr),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_resume(cmd_resume),
    .q_active(q_active), .cur_desc_addr(cur_desc_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_zlp(out_zlp), .irq_pend(irq_pend)
);

// File: tb/tb_txq_engine.sv
`timescale 1ns/1ps
module tb_txq_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_start_addr = '0;
    logic        cmd_start = 1'b0, cmd_stop = 1'b0, cmd_resume = 1'b0;
    logic        q_active;
    logic [31:0] cur_desc_addr;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        out_valid, out_ready, out_last, out_zlp;
    logic [7:0]  out_data;
    logic [1:0]  irq_en = '0, irq_clr = '0, irq_pend;
    logic        irq_done, irq_lenerr;

    int checks = 0;
    int errors = 0;
    int rx_n = 0;
    int base = 0;
    logic [7:0] rx_data [64];
    logic       rx_last [64];
    logic       rx_zlp  [64];
    logic [31:0] mem [256];
    logic [1:0]  rdy_mode = 2'd0;
    logic [1:0]  sc = 2'd0;

    always #2 clk = ~clk;

    txq_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_start_addr(cfg_start_addr),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_resume(cmd_resume),
        .q_active(q_active), .cur_desc_addr(cur_desc_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .out_zlp(out_zlp),
        .irq_en(irq_en), .irq_clr(irq_clr), .irq_pend(irq_pend),
        .irq_done(irq_done), .irq_lenerr(irq_lenerr)
    );

    assign out_ready = (rdy_mode == 2'd0) || (rdy_mode == 2'd1 && sc != 2'd0);

    always @(posedge clk) begin
        sc <= (sc == 2'd2) ? 2'd0 : sc + 2'd1;
        if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
        if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
        if (rst_n && out_valid && out_ready && rx_n < 64) begin
            rx_data[rx_n] = out_data;
            rx_last[rx_n] = out_last;
            rx_zlp[rx_n]  = out_zlp;
            rx_n = rx_n + 1;
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_desc(input int a, input logic [31:0] w0, w1, w2, w3);
        mem[a/4]     = w0;
        mem[a/4 + 1] = w1;
        mem[a/4 + 2] = w2;
        mem[a/4 + 3] = w3;
    endtask

    task automatic prep();
        @(negedge clk);
        cmd_stop = 1'b1; irq_clr = 2'b11; rdy_mode = 2'd0;
        @(negedge clk);
        cmd_stop = 1'b0; irq_clr = 2'b00;
        run(2);
        base = rx_n;
    endtask

    task automatic go(input int a);
        cfg_start_addr = a; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic pulse_resume();
        cmd_resume = 1'b1;
        @(negedge clk);
        cmd_resume = 1'b0;
    endtask

    task automatic chk_bytes(input string req, input int idx0, input int a, input int len);
        for (int i = 0; i < len; i++) begin
            chk(req, "byte", rx_data[base+idx0+i], pat(a+i));
            chk(req, "last flag", rx_last[base+idx0+i], (i == len-1));
            chk(req, "zlp flag", rx_zlp[base+idx0+i], 0);
        end
    endtask

    task automatic t_reset();
        chk("R1", "q_active", q_active, 0);
        chk("R1", "out_valid", out_valid, 0);
        chk("R1", "cur_desc_addr", cur_desc_addr, 0);
        chk("R1", "irq_pend", irq_pend, 0);
        chk("R1", "irqs", {irq_done, irq_lenerr}, 0);
        chk("R1", "mem access", {mem_rd, mem_wr}, 0);
    endtask

    task automatic t_single();
        int n;
        prep();
        irq_en = 2'b11;
        wr_desc(32'h40, 32'h81, 32'hC0, 32'h102, 32'd5);
        cfg_start_addr = 32'h40; cmd_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_start = 1'b0;
        chk("R2", "cur after start", cur_desc_addr, 32'h40);
        chk("R2", "active after start", q_active, 1);
        n = 0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (out_valid) begin n = i; break; end
        end
        chk("R2", "first byte latency", n, 11);
        for (int i = 0; i < 40; i++) begin
            if (out_valid && out_last) break;
            @(negedge clk);
        end
        @(negedge clk);
        chk("R6", "own kept at final handshake", mem[32'h40/4][0], 1);
        chk("R10", "done not yet pending", irq_pend[0], 0);
        @(negedge clk);
        chk("R6", "word0 written back", mem[32'h40/4], 32'h80);
        chk("R10", "done pending with write-back", irq_pend[0], 1);
        chk("R6", "cur follows link", cur_desc_addr, 32'hC0);
        run(30);
        chk("R4", "byte count", rx_n - base, 5);
        chk_bytes("R4", 0, 32'h102, 5);
        chk("R10", "irq_done", irq_done, 1);
        chk("R3", "parked on sw-owned stays active", q_active, 1);
        chk("R3", "parked cur", cur_desc_addr, 32'hC0);
        irq_clr = 2'b01;
        @(negedge clk);
        irq_clr = 2'b00;
        chk("R11", "done cleared by w1c", irq_pend[0], 0);
        chk("R11", "irq_done low", irq_done, 0);
    endtask

    task automatic t_chain();
        prep();
        irq_en = 2'b11;
        rdy_mode = 2'd1;
        wr_desc(32'h10, 32'h01, 32'h80, 32'h203, 32'd6);
        wr_desc(32'h80, 32'hC1, 32'hC0, 32'h150, 32'd3);
        go(32'h10);
        run(200);
        chk("R5", "beats under stall", rx_n - base, 10);
        chk_bytes("R5", 0, 32'h203, 6);
        chk_bytes("R4", 6, 32'h150, 3);
        chk("R7", "zlp beat", rx_zlp[base+9], 1);
        chk("R7", "zlp beat last", rx_last[base+9], 1);
        chk("R6", "first wb", mem[32'h10/4], 32'h00);
        chk("R6", "second wb keeps flags", mem[32'h80/4], 32'hC0);
        chk("R6", "cur at end", cur_desc_addr, 32'hC0);
    endtask

    task automatic t_park();
        prep();
        wr_desc(32'h20, 32'h80, 32'hC0, 32'h110, 32'd2);
        go(32'h20);
        run(30);
        chk("R3", "no bytes when sw-owned", rx_n - base, 0);
        chk("R3", "cur held", cur_desc_addr, 32'h20);
        chk("R3", "active held", q_active, 1);
        chk("R3", "no write-back", mem[32'h20/4], 32'h80);
        chk("R3", "no done", irq_pend[0], 0);
        mem[32'h20/4] = 32'h81;
        pulse_resume();
        run(40);
        chk("R3", "bytes after resume", rx_n - base, 2);
        chk_bytes("R3", 0, 32'h110, 2);
        chk("R3", "wb after resume", mem[32'h20/4], 32'h80);
        chk("R3", "cur after resume", cur_desc_addr, 32'hC0);
        cfg_start_addr = 32'h20; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        run(20);
        chk("R13", "start while active ignored", cur_desc_addr, 32'hC0);
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        chk("R12", "stop while parked", q_active, 0);
        pulse_resume();
        run(20);
        chk("R13", "resume while idle ignored", q_active, 0);
        chk("R13", "no bytes after idle resume", rx_n - base, 2);
    endtask

    task automatic t_bypass();
        prep();
        wr_desc(32'h30, 32'h85, 32'hC0, 32'h120, 32'd3);
        go(32'h30);
        run(40);
        chk("R8", "no bytes on bypass", rx_n - base, 0);
        chk("R8", "bypass wb", mem[32'h30/4], 32'h84);
        chk("R8", "bypass advance", cur_desc_addr, 32'hC0);
        chk("R8", "bypass done", irq_pend[0], 1);
    endtask

    task automatic t_zero();
        prep();
        irq_en = 2'b11;
        wr_desc(32'h50, 32'h81, 32'hC0, 32'h140, 32'd0);
        go(32'h50);
        run(30);
        chk("R9", "lenerr pending", irq_pend[1], 1);
        chk("R9", "irq_lenerr", irq_lenerr, 1);
        chk("R9", "no bytes", rx_n - base, 0);
        chk("R9", "no wb", mem[32'h50/4], 32'h81);
        chk("R9", "cur held", cur_desc_addr, 32'h50);
        chk("R9", "active held", q_active, 1);
        mem[32'h50/4] = 32'h85;
        pulse_resume();
        run(30);
        chk("R9", "advance after fix", cur_desc_addr, 32'hC0);
        chk("R9", "wb after fix", mem[32'h50/4], 32'h84);
        irq_clr = 2'b10;
        @(negedge clk);
        irq_clr = 2'b00;
        chk("R11", "lenerr cleared", irq_pend[1], 0);
        chk("R11", "done untouched", irq_pend[0], 1);
    endtask

    task automatic t_gate();
        prep();
        irq_en = 2'b00;
        wr_desc(32'h60, 32'h01, 32'hC0, 32'h130, 32'd1);
        go(32'h60);
        run(30);
        chk("R10", "byte sent", rx_n - base, 1);
        chk("R10", "no done without ioc", irq_pend[0], 0);
        prep();
        wr_desc(32'h70, 32'h81, 32'hC0, 32'h131, 32'd1);
        go(32'h70);
        run(30);
        chk("R11", "pending while disabled", irq_pend[0], 1);
        chk("R11", "irq masked", irq_done, 0);
        irq_en = 2'b01;
        @(negedge clk);
        chk("R11", "irq after enable", irq_done, 1);
    endtask

    task automatic t_stop();
        prep();
        rdy_mode = 2'd2;
        wr_desc(32'h90, 32'h81, 32'hC0, 32'h160, 32'd8);
        go(32'h90);
        for (int i = 0; i < 40; i++) begin
            if (out_valid) break;
            @(negedge clk);
        end
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        run(2);
        chk("R12", "beat held after stop", out_valid, 1);
        chk("R12", "active until handshake", q_active, 1);
        chk("R12", "held byte", out_data, pat(32'h160));
        rdy_mode = 2'd0;
        @(negedge clk);
        chk("R12", "inactive after handshake", q_active, 0);
        chk("R12", "valid dropped", out_valid, 0);
        run(10);
        chk("R12", "one byte only", rx_n - base, 1);
        chk("R12", "no wb on stop", mem[32'h90/4], 32'h81);
        chk("R12", "no done on stop", irq_pend[0], 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++)
            mem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
        wr_desc(32'hC0, 32'h0, 32'h0, 32'h0, 32'h0);
        run(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_chain();
        t_park();
        t_bypass();
        t_zero();
        t_gate();
        t_stop();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule